// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a requester that speaks in whole addresses and an asynchronous DRAM whose address pins carry a row half and a column half in turn. Each accepted request opens a row by driving the row half and lowering the row strobe, and then issues column strobes with the column half on the same pins. Every strobe delay is a parameter in clock cycles. Opening a row costs far more cycles than one column access, so the block lets a single open row serve several column strobes.

There are three access modes. A single access opens the row, makes one column access and closes the row. A nibble access supplies one column and issues four column strobes, with the low column bits coming from an internal counter. A page access keeps the row open after its column strobe, so that later page requests to the same row need only a column strobe. Refresh requests come in from outside. Each one is served as a cycle that lowers only the row strobe, using the row address supplied with the request. Read data is captured a fixed number of cycles after each column strobe falls and is marked with a one-cycle valid pulse.

Top module: `dram_strobe_seq`

## Requirements
- R1: After reset both strobes are high (inactive), `rd_valid` and `ref_ack` are low, and `req_ready` is high when no refresh is requested.
- R2: The row half is on `dram_addr` when `dram_ras_n` falls. The column half is on `dram_addr` when `dram_cas_n` falls. The column address is already on the pins in the cycle before the column strobe falls and does not change while that strobe stays low.
- R3: `dram_cas_n` falls no sooner than T_RCD+1 cycles after `dram_ras_n` falls. `dram_ras_n` stays high for at least T_RP cycles before it falls again.
- R4: Mode 2'b00 (single) makes one row activation and one column strobe, then closes the row. Mode 2'b11 behaves the same way.
- R5: Mode 2'b01 (nibble) makes four column strobes in one activation. The two low column bits count up from the given column and wrap inside the aligned group of four. The upper bits stay fixed. A nibble write stores the request's data at all four columns.
- R6: Mode 2'b10 (page) leaves the row strobe low after the column access. A later page request to the same row adds only a column strobe, with no new row activation.
- R7: While a row is open, a request to a different row, or in mode single or nibble, closes the row, waits out the precharge and then reactivates.
- R8: For a read, `rd_data` takes the value of `dram_dq_in` sampled CAS_LAT cycles after `dram_cas_n` falls, and `rd_valid` is high for exactly that one cycle.
- R9: During a write column access, `dram_we_n` is low and `dram_dq_oe` is high with `dram_dq_out` equal to the request data. During a read, `dram_we_n` stays high.
- R10: `ref_ack` goes high only while the row strobe is high and the sequencer is idle. The refresh lowers the row strobe with `ref_row` on the pins and issues no column strobe. When a refresh and a request arrive in the same cycle, the refresh wins. A refresh request closes an open page row.
- R11: `dram_cas_n` is never low while `dram_ras_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 00 single, 01 nibble, 10 page, 11 single |
| req_row | input | HALF_W | Row half of the address |
| req_col | input | HALF_W | Column half of the address |
| req_wdata | input | DATA_W | Write data |
| ref_req | input | 1 | Refresh wanted |
| ref_row | input | HALF_W | Row to refresh |
| ref_ack | output | 1 | Refresh taken on this edge |
| dram_addr | output | HALF_W | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data returned by memory |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |

## Verification
A refresh request and an access request can reach the arbiter in the same cycle. This can happen while the sequencer is idle, or while a page row is open and the request would hit that row. The bench raises both inputs on the same edge in each of these two states. It then checks that `req_ready` stays low in the cycle where `ref_ack` is high. It also checks that the recorded row-strobe addresses appear in the order refresh row first, request row second. The check then confirms that the request still completes with correct data after the refresh precharge.

// File: rtl/dseq_pkg.sv
// Shared types for the DRAM access sequencer.
// Assumes: mode codes match the req_mode port encoding.
package dseq_pkg;

    typedef enum logic [1:0] {
        M_SINGLE = 2'b00,
        M_NIBBLE = 2'b01,
        M_PAGE   = 2'b10,
        M_ALT    = 2'b11
    } acc_mode_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RSET,
        S_ACT,
        S_CSET,
        S_CAS,
        S_OPEN,
        S_PRE,
        S_FSET,
        S_FACT
    } seq_state_t;

endpackage

// File: rtl/dseq_timer.sv
// Down-counting delay timer.
// Loading N makes done rise N cycles later; done is high while the count is zero.
// Assumes: load has priority over counting.
module dseq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Count down toward zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/dseq_colgen.sv
// Column address generator.
// Holds the current column and steps its low bits inside an aligned group for burst accesses.
// Assumes: BURST_LEN is a power of two no larger than 2**COL_W.
module dseq_colgen #(
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] load_col,
    input  logic             step,
    output logic [COL_W-1:0] col,
    output logic             last
);
    localparam int LOW_W = $clog2(BURST_LEN);

    logic [COL_W-1:0] col_q;
    logic [LOW_W-1:0] beat_q;

    // Load a fresh column or advance the wrapped low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            beat_q <= '0;
        end else if (load) begin
            col_q  <= load_col;
            beat_q <= '0;
        end else if (step) begin
            col_q  <= {col_q[COL_W-1:LOW_W], col_q[LOW_W-1:0] + 1'b1};
            beat_q <= beat_q + 1'b1;
        end
    end

    assign col  = col_q;
    assign last = (beat_q == LOW_W'(BURST_LEN - 1));
endmodule

// File: rtl/dseq_rdcap.sv
// Read data capture.
// Samples dq_in CAS_LAT cycles after a fire pulse and raises a one-cycle valid.
// Assumes: fire is a single-cycle pulse in the first cycle of a low column strobe.
module dseq_rdcap #(
    parameter int DATA_W  = 8,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic grab;

    generate
        if (CAS_LAT == 1) begin : g_direct
            assign grab = fire;
        end else begin : g_delay
            logic [CAS_LAT-2:0] dly_q;
            // Delay the fire pulse by CAS_LAT-1 cycles.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dly_q <= '0;
                else
                    dly_q <= (dly_q << 1) | (CAS_LAT-1)'(fire);
            end
            assign grab = dly_q[CAS_LAT-2];
        end
    endgenerate

    // Capture the data word and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= grab;
            if (grab)
                rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/dram_strobe_seq.sv
// Multiplexed-address DRAM access sequencer.
// Turns whole-address requests into row/column strobe sequences in single, nibble and page modes.
// Serves external refresh requests as row-strobe-only cycles.
// Assumes: T_* >= 1, 1 <= CAS_LAT <= T_CAS, NIBBLE_LEN a power of two.
module dram_strobe_seq
    import dseq_pkg::*;
#(
    parameter int HALF_W     = 10,
    parameter int DATA_W     = 8,
    parameter int T_RCD      = 5,
    parameter int T_CAS      = 2,
    parameter int T_RP       = 4,
    parameter int T_RAS      = 6,
    parameter int CAS_LAT    = 2,
    parameter int NIBBLE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    input  logic [HALF_W-1:0] req_row,
    input  logic [HALF_W-1:0] req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ref_req,
    input  logic [HALF_W-1:0] ref_row,
    output logic              ref_ack,
    output logic [HALF_W-1:0] dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int TMAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TMAX_B = (T_RP > T_RAS) ? T_RP : T_RAS;
    localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TMR_W  = $clog2(TMAX + 1);

    seq_state_t        state_q, state_d;
    acc_mode_t         mode_q;
    acc_mode_t         in_mode;
    logic [HALF_W-1:0] row_q, ref_row_q, col;
    logic              write_q, cas_first_q;
    logic [DATA_W-1:0] wdata_q;
    logic              tmr_load, tmr_done, col_step, col_last;
    logic [TMR_W-1:0]  tmr_val;
    logic              accept, row_hit, in_col;

    assign in_mode = acc_mode_t'(req_mode);
    assign row_hit = (req_row == row_q);

    // Request and refresh arbitration: refresh wins, page hits join an open row.
    always_comb begin
        req_ready = 1'b0;
        if (!ref_req) begin
            if (state_q == S_IDLE)
                req_ready = 1'b1;
            else if (state_q == S_OPEN && in_mode == M_PAGE && row_hit)
                req_ready = 1'b1;
        end
    end

    assign accept  = req_valid && req_ready;
    assign ref_ack = ref_req && (state_q == S_IDLE);

    dseq_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dseq_colgen #(.COL_W(HALF_W), .BURST_LEN(NIBBLE_LEN)) u_colgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_col (req_col),
        .step     (col_step),
        .col      (col),
        .last     (col_last)
    );

    dseq_rdcap #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_rdcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (cas_first_q && !write_q),
        .dq_in    (dram_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Next-state and timer-load decisions for the strobe sequence.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        col_step = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (ref_ack)
                    state_d = S_FSET;
                else if (accept)
                    state_d = S_RSET;
            end
            S_RSET: begin
                state_d  = S_ACT;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_RCD - 1);
            end
            S_ACT: begin
                if (tmr_done)
                    state_d = S_CSET;
            end
            S_CSET: begin
                state_d  = S_CAS;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_CAS - 1);
            end
            S_CAS: begin
                if (tmr_done) begin
                    if (mode_q == M_NIBBLE && !col_last) begin
                        col_step = 1'b1;
                        state_d  = S_CSET;
                    end else if (mode_q == M_PAGE) begin
                        state_d = S_OPEN;
                    end else begin
                        state_d  = S_PRE;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(T_RP - 1);
                    end
                end
            end
            S_OPEN: begin
                if (accept) begin
                    state_d = S_CSET;
                end else if (ref_req || req_valid) begin
                    state_d  = S_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RP - 1);
                end
            end
            S_PRE: begin
                if (tmr_done)
                    state_d = S_IDLE;
            end
            S_FSET: begin
                state_d  = S_FACT;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_RAS - 1);
            end
            S_FACT: begin
                if (tmr_done) begin
                    state_d  = S_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(T_RP - 1);
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Latch the attributes of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            mode_q  <= M_SINGLE;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            row_q   <= req_row;
            mode_q  <= in_mode;
            write_q <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // Latch the row to refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_row_q <= '0;
        else if (ref_ack)
            ref_row_q <= ref_row;
    end

    // Mark the first cycle of each low column strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cas_first_q <= 1'b0;
        else
            cas_first_q <= (state_q == S_CSET);
    end

    // Pin decode from the state.
    assign in_col      = (state_q == S_CSET) || (state_q == S_CAS);
    assign dram_cas_n  = (state_q != S_CAS);
    assign dram_we_n   = !(in_col && write_q);
    assign dram_dq_oe  = in_col && write_q;
    assign dram_dq_out = wdata_q;

    // Row strobe is low in every state that holds a row open.
    always_comb begin
        case (state_q)
            S_ACT, S_CSET, S_CAS, S_OPEN, S_FACT: dram_ras_n = 1'b0;
            default:                              dram_ras_n = 1'b1;
        endcase
    end

    // Address multiplexer: row half, column half, or refresh row.
    always_comb begin
        case (state_q)
            S_CSET, S_CAS: dram_addr = col;
            S_FSET, S_FACT: dram_addr = ref_row_q;
            default:        dram_addr = row_q;
        endcase
    end
endmodule

// File: rtl/dseq_chk.sv
// Protocol checker for the DRAM access sequencer, bound to the top module.
// Assumes: strobes are active low and reset is synchronous active low.
module dseq_chk #(
    parameter int HALF_W = 10,
    parameter int T_RCD  = 5,
    parameter int T_RP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              dq_oe,
    input logic              rd_valid,
    input logic              ref_ack,
    input logic [HALF_W-1:0] addr
);
    localparam int CW = $clog2(T_RCD + T_RP + 2) + 1;

    logic [CW-1:0] lo_cnt, hi_cnt;

    // Count consecutive cycles the row strobe has been low or high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= CW'(T_RP);
        end else if (ras_n) begin
            lo_cnt <= '0;
            if (~&hi_cnt) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
            if (~&lo_cnt) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    a_r11_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    a_r2_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(addr));

    a_r2_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !$past(cas_n)) |-> $stable(addr));

    a_r3_row_to_col: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (lo_cnt >= CW'(T_RCD + 1)));

    a_r3_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= CW'(T_RP)));

    a_r9_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !we_n) |-> dq_oe);

    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r10_ack_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (ras_n && cas_n));
endmodule

bind dram_strobe_seq dseq_chk #(
    .HALF_W (HALF_W),
    .T_RCD  (T_RCD),
    .T_RP   (T_RP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .we_n     (dram_we_n),
    .dq_oe    (dram_dq_oe),
    .rd_valid (rd_valid),
    .ref_ack  (ref_ack),
    .addr     (dram_addr)
);

// File: tb/dram_strobe_seq_tb.sv
// Scoreboard bench: driver tasks queue expected row strobes, column strobes and read words;
// a negedge monitor pops and compares them against the pins.
module dram_strobe_seq_tb;
    localparam int HW      = 5;
    localparam int DW      = 8;
    localparam int T_RCD   = 3;
    localparam int T_CAS   = 2;
    localparam int T_RP    = 3;
    localparam int T_RAS   = 4;
    localparam int CAS_LAT = 2;
    localparam int MEM_N   = 1 << (2 * HW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_mode = 2'b00;
    logic [HW-1:0] req_row = '0, req_col = '0, ref_row = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ref_req = 1'b0;
    logic          req_ready, ref_ack, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe, rd_valid;
    logic [HW-1:0] dram_addr;
    logic [DW-1:0] dram_dq_out, dram_dq_in, rd_data;

    always #5 clk = ~clk;

    dram_strobe_seq #(
        .HALF_W(HW), .DATA_W(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_RP(T_RP), .T_RAS(T_RAS), .CAS_LAT(CAS_LAT), .NIBBLE_LEN(4)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_mode(req_mode), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .ref_req(ref_req), .ref_row(ref_row), .ref_ack(ref_ack),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Behavioural memory and the bench's reference copy.
    logic [DW-1:0] dmem    [0:MEM_N-1];
    logic [DW-1:0] ref_mem [0:MEM_N-1];
    logic [HW-1:0] mrow = '0;
    logic          m_ras_prev = 1'b1;

    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            dmem[i]    = DW'(i * 29 + 7);
            ref_mem[i] = DW'(i * 29 + 7);
        end
    end

    always @(negedge clk) begin
        if (!dram_ras_n && m_ras_prev) mrow = dram_addr;
        m_ras_prev = dram_ras_n;
        if (!dram_cas_n && !dram_we_n) dmem[{mrow, dram_addr}] = dram_dq_out;
    end

    assign dram_dq_in = dram_cas_n ? '0 : dmem[{mrow, dram_addr}];

    // Scoreboard state.
    typedef struct packed {
        logic          we;
        logic [HW-1:0] col;
        logic [DW-1:0] wd;
    } col_exp_t;

    logic [HW-1:0] exp_row_q [$];
    col_exp_t      exp_col_q [$];
    logic [DW-1:0] exp_rd_q  [$];
    int unsigned   exp_t_q   [$];
    int            total = 0, bad = 0;
    logic          finished = 1'b0;
    logic          bench_open = 1'b0;
    logic [HW-1:0] bench_row = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare strobe addresses, spacing and read data.
    int unsigned ncyc = 0, t_fall = 0, t_rise = 0;
    logic        had_rise = 1'b0, p_ras = 1'b1, p_cas = 1'b1;

    always @(negedge clk) begin
        ncyc++;
        if (rst_n) begin
            if (p_ras && !dram_ras_n) begin
                if (exp_row_q.size() == 0)
                    chk(0, "R2", "unexpected row strobe", 32'(dram_addr), 0);
                else begin
                    logic [HW-1:0] er;
                    er = exp_row_q.pop_front();
                    chk(dram_addr == er, "R2", "row address", 32'(dram_addr), 32'(er));
                end
                if (had_rise)
                    chk((ncyc - t_rise) >= T_RP, "R3", "precharge cycles", ncyc - t_rise, T_RP);
                t_fall = ncyc;
            end
            if (!p_ras && dram_ras_n) begin
                t_rise   = ncyc;
                had_rise = 1'b1;
            end
            if (p_cas && !dram_cas_n) begin
                chk((ncyc - t_fall) >= T_RCD + 1, "R3", "row to column cycles", ncyc - t_fall, T_RCD + 1);
                if (exp_col_q.size() == 0)
                    chk(0, "R4", "unexpected column strobe", 32'(dram_addr), 0);
                else begin
                    col_exp_t ec;
                    ec = exp_col_q.pop_front();
                    chk(dram_addr == ec.col, "R5", "column address", 32'(dram_addr), 32'(ec.col));
                    chk(dram_we_n == !ec.we, "R9", "write enable", 32'(dram_we_n), 32'(!ec.we));
                    if (ec.we)
                        chk(dram_dq_oe && dram_dq_out == ec.wd, "R9", "write data",
                            32'(dram_dq_out), 32'(ec.wd));
                    else
                        exp_t_q.push_back(ncyc + CAS_LAT);
                end
            end
            if (rd_valid) begin
                if (exp_rd_q.size() == 0 || exp_t_q.size() == 0)
                    chk(0, "R8", "unexpected read valid", 32'(rd_data), 0);
                else begin
                    logic [DW-1:0] ed;
                    int unsigned   et;
                    ed = exp_rd_q.pop_front();
                    et = exp_t_q.pop_front();
                    chk(rd_data == ed, "R8", "read data", 32'(rd_data), 32'(ed));
                    chk(ncyc == et, "R8", "read latency", ncyc, et);
                end
            end
            if (ref_ack)
                chk(dram_ras_n && dram_cas_n, "R10", "refresh ack with row open",
                    32'({dram_ras_n, dram_cas_n}), 32'h3);
        end
        p_ras = dram_ras_n;
        p_cas = dram_cas_n;
    end

    // Driver helpers.
    task automatic push_exp(input logic [1:0] mode, input logic we, input logic [HW-1:0] row,
                            input logic [HW-1:0] col, input logic [DW-1:0] wd);
        int nb;
        if (!(mode == 2'b10 && bench_open && row == bench_row))
            exp_row_q.push_back(row);
        bench_open = (mode == 2'b10);
        bench_row  = row;
        nb = (mode == 2'b01) ? 4 : 1;
        for (int b = 0; b < nb; b++) begin
            logic [HW-1:0] c;
            col_exp_t      e;
            c = {col[HW-1:2], col[1:0] + 2'(b)};
            e.we = we; e.col = c; e.wd = wd;
            exp_col_q.push_back(e);
            if (we) ref_mem[{row, c}] = wd;
            else    exp_rd_q.push_back(ref_mem[{row, c}]);
        end
    endtask

    task automatic drive_req(input logic [1:0] mode, input logic we, input logic [HW-1:0] row,
                             input logic [HW-1:0] col, input logic [DW-1:0] wd);
        req_mode = mode; req_write = we; req_row = row; req_col = col; req_wdata = wd;
        req_valid = 1'b1;
    endtask

    task automatic send(input logic [1:0] mode, input logic we, input logic [HW-1:0] row,
                        input logic [HW-1:0] col, input logic [DW-1:0] wd);
        push_exp(mode, we, row, col, wd);
        @(negedge clk);
        drive_req(mode, we, row, col, wd);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic send_ref(input logic [HW-1:0] row);
        exp_row_q.push_back(row);
        bench_open = 1'b0;
        @(negedge clk);
        ref_req = 1'b1; ref_row = row;
        #1;
        while (!ref_ack) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        ref_req = 1'b0;
    endtask

    // Refresh and request raised on the same edge; refresh must be taken first.
    task automatic collide(input logic [1:0] mode, input logic we, input logic [HW-1:0] row,
                           input logic [HW-1:0] col, input logic [DW-1:0] wd,
                           input logic [HW-1:0] rrow);
        bit ref_done, req_done, a_ref, a_req;
        ref_done = 0; req_done = 0;
        exp_row_q.push_back(rrow);
        bench_open = 1'b0;
        push_exp(mode, we, row, col, wd);
        @(negedge clk);
        ref_req = 1'b1; ref_row = rrow;
        drive_req(mode, we, row, col, wd);
        #1;
        while (!(ref_done && req_done)) begin
            a_ref = !ref_done && ref_ack;
            a_req = !req_done && req_valid && req_ready;
            if (a_ref)
                chk(!req_ready, "R10", "request taken beside refresh", 32'(req_ready), 0);
            if (!ref_done && a_req)
                chk(0, "R10", "request before refresh", 1, 0);
            @(posedge clk); #1;
            if (a_ref) begin ref_req = 1'b0; ref_done = 1; end
            if (a_req) begin req_valid = 1'b0; req_done = 1; end
            if (!(ref_done && req_done)) begin @(negedge clk); #1; end
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(dram_ras_n && dram_cas_n, "R1", "strobes after reset", 32'({dram_ras_n, dram_cas_n}), 32'h3);
        chk(!rd_valid && !ref_ack, "R1", "valid/ack after reset", 32'({rd_valid, ref_ack}), 0);
        chk(req_ready, "R1", "ready after reset", 32'(req_ready), 1);

        // R4, R9, R8: single write then read back
        send(2'b00, 1'b1, 5'd3, 5'd5, 8'hAA);
        send(2'b00, 1'b0, 5'd3, 5'd5, 8'h00);
        send(2'b00, 1'b0, 5'd17, 5'd30, 8'h00);

        // R5: nibble read with wrap, nibble write fill, read back
        send(2'b01, 1'b0, 5'd7, 5'd6, 8'h00);
        send(2'b01, 1'b1, 5'd7, 5'd9, 8'h3C);
        send(2'b01, 1'b0, 5'd7, 5'd8, 8'h00);

        // R6: page accesses share one activation
        send(2'b10, 1'b0, 5'd2, 5'd1, 8'h00);
        send(2'b10, 1'b1, 5'd2, 5'd30, 8'h5A);
        send(2'b10, 1'b0, 5'd2, 5'd30, 8'h00);
        send(2'b10, 1'b0, 5'd2, 5'd0, 8'h00);
        repeat (10) @(negedge clk);
        #1;
        chk(!dram_ras_n, "R6", "row held open after page access", 32'(dram_ras_n), 0);

        // R7: page miss to another row, then single to that open row
        send(2'b10, 1'b0, 5'd9, 5'd4, 8'h00);
        send(2'b00, 1'b0, 5'd9, 5'd4, 8'h00);

        // R10: refresh while idle
        send_ref(5'd12);

        // R10: refresh collides with a page hit on an open row
        send(2'b10, 1'b0, 5'd4, 5'd3, 8'h00);
        collide(2'b10, 1'b0, 5'd4, 5'd2, 8'h00, 5'd13);

        // R10: refresh collides with a request while idle
        send(2'b00, 1'b0, 5'd20, 5'd20, 8'h00);
        collide(2'b00, 1'b1, 5'd1, 5'd1, 8'h77, 5'd14);
        send(2'b00, 1'b0, 5'd1, 5'd1, 8'h00);

        // R4: mode 11 acts as single
        send(2'b11, 1'b0, 5'd6, 5'd11, 8'h00);

        repeat (40) @(negedge clk);
        chk(exp_row_q.size() == 0, "R4", "row strobes missing", exp_row_q.size(), 0);
        chk(exp_col_q.size() == 0, "R5", "column strobes missing", exp_col_q.size(), 0);
        chk(exp_rd_q.size() == 0, "R8", "read results missing", exp_rd_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule